// File: doc/BRIEF.md
# Forwarding Counter Table with Deferred Write

The block keeps one counter per address in a single-port-read, single-port-write synchronous RAM and serves one read-modify-write update per clock. A request names an address and an amount to add. The block reads the stored count, adds the amount, returns the new count, and stores it back. The count wraps around when it overflows.

The RAM read takes one cycle, so a naive design would stall the next request until the previous write had landed. Here the freshly computed value is parked in a holding register together with its address. It is written to the RAM one cycle later, in the same cycle that the RAM serves the read for a later request. Each incoming request compares its address against the parked entry and against the entry being written to the RAM. On a match it takes that newer value as its operand and ignores the stale RAM data. Back-to-back hits on one address therefore count correctly at full rate.

On reset the block walks every RAM entry and writes zero, with its ready output low for the length of the sweep. Requests offered while ready is low are not taken.

Top module: `rmw_count_table`

## Requirements
- R1: While `rst` is high and for exactly DEPTH cycles after it falls, `req_ready` is 0. After that every entry holds zero, so the first update of any address returns its increment.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both 1) produces exactly one response: `rsp_valid` is 1 for the one cycle that follows the next rising edge. No response occurs otherwise.
- R3: A response carries the request's address on `rsp_addr`, and on `rsp_value` the previous count of that address plus `req_incr`, modulo 2^CNT_W.
- R4: Requests to one address on consecutive cycles return consecutive running sums, with no stall. For example, three increments of 1 from n return n+1, n+2 and n+3.
- R5: A request to an address updated two cycles earlier, with a different address in between, sees the earlier update (the value whose RAM write is still in progress).
- R6: After one or more idle cycles, a request to a previously updated address returns the stored count plus its increment.
- R7: A sum of at least 2^CNT_W wraps: the stored count is the low CNT_W bits of the sum.
- R8: A request offered while `req_ready` is 0 has no effect. It gives no response and does not change the table.
- R9: Responses come out in the order the requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; starts the clearing sweep |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W | Counter index |
| req_incr | input | CNT_W | Amount added to the counter |
| rsp_valid | output | 1 | Response present (one cycle per accepted request) |
| rsp_addr | output | ADDR_W | Counter index of the response |
| rsp_value | output | CNT_W | Updated count |

## Verification
The bench builds the block with DEPTH=16 and CNT_W=8. With only sixteen entries, random addresses biased toward three hot entries land on the forwarding paths on most cycles. Both the parked-entry match and the write-in-progress match are exercised, along with misses. The 8-bit count overflows within a few updates, so wrap-around happens often under random increments and also in a directed case. The short clearing sweep lets the bench count the ready-low cycles exactly and reset again in the middle of traffic.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    // Where the read-modify-write takes its operand from.
    typedef enum logic [1:0] {
        SRC_RAM  = 2'd0,
        SRC_HOLD = 2'd1,
        SRC_WB   = 2'd2
    } opnd_src_e;

    // The parked (newest) entry wins over the one being written to RAM.
    function automatic opnd_src_e pick_src(input logic hold_hit, input logic wb_hit);
        if (hold_hit)
            return SRC_HOLD;
        else if (wb_hit)
            return SRC_WB;
        else
            return SRC_RAM;
    endfunction

    // Phase of the table controller.
    typedef enum logic {
        PH_CLEAR = 1'b0,
        PH_RUN   = 1'b1
    } table_phase_e;

endpackage

// File: rtl/cnt_clear_seq.sv
module cnt_clear_seq
    import cnt_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              busy,
    output logic [ADDR_W-1:0] wr_addr
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    table_phase_e      phase;
    logic [ADDR_W-1:0] ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_CLEAR;
            ptr   <= '0;
        end else if (phase == PH_CLEAR) begin
            if (ptr == LAST) begin
                phase <= PH_RUN;
            end else begin
                ptr <= ptr + ADDR_W'(1);
            end
        end
    end

    assign busy    = (phase == PH_CLEAR);
    assign wr_addr = ptr;

    // R1
    sweep_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(ptr) == LAST);

    // R1
    sweep_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> ptr == $past(ptr) + ADDR_W'(1));

endmodule

// File: rtl/cnt_ram.sv
module cnt_ram #(
    parameter int DEPTH  = 256,
    parameter int WIDTH  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Read returns the contents before a same-cycle write (read-first).
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/cnt_fwd_stage.sv
module cnt_fwd_stage
    import cnt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    // request whose RAM read was issued last cycle
    input  logic              s1_valid,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [CNT_W-1:0]  s1_incr,
    input  logic [CNT_W-1:0]  ram_rdata,
    // parked entry: drives the RAM write port and the response
    output logic              hold_valid,
    output logic [ADDR_W-1:0] hold_addr,
    output logic [CNT_W-1:0]  hold_data
);

    // Entry written to RAM in the previous cycle; a read issued in that
    // same cycle returned the old contents, so it is bypassed too.
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [CNT_W-1:0]  wb_data;

    logic              hold_hit;
    logic              wb_hit;
    opnd_src_e         src;
    logic [CNT_W-1:0]  operand;
    logic [CNT_W-1:0]  sum;

    assign hold_hit = hold_valid && (hold_addr == s1_addr);
    assign wb_hit   = wb_valid && (wb_addr == s1_addr);
    assign src      = pick_src(hold_hit, wb_hit);

    always_comb begin
        case (src)
            SRC_HOLD: operand = hold_data;
            SRC_WB:   operand = wb_data;
            default:  operand = ram_rdata;
        endcase
    end

    assign sum = operand + s1_incr;   // wraps modulo 2^CNT_W

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_valid <= 1'b0;
            hold_addr  <= '0;
            hold_data  <= '0;
            wb_valid   <= 1'b0;
            wb_addr    <= '0;
            wb_data    <= '0;
        end else begin
            hold_valid <= s1_valid;
            if (s1_valid) begin
                hold_addr <= s1_addr;
                hold_data <= sum;
            end
            wb_valid <= hold_valid;
            wb_addr  <= hold_addr;
            wb_data  <= hold_data;
        end
    end

    // R4
    back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_valid && $past(hold_valid) && !$past(rst) && hold_addr == $past(hold_addr))
        |-> hold_data == CNT_W'($past(hold_data) + $past(s1_incr)));

    // R5
    wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
        hold_valid |=> (wb_valid && wb_addr == $past(hold_addr) && wb_data == $past(hold_data)));

    // R6
    no_stale_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !hold_valid);

endmodule

// File: rtl/rmw_count_table.sv
module rmw_count_table
    import cnt_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_incr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [CNT_W-1:0]  rsp_value
);

    logic              clr_busy;
    logic [ADDR_W-1:0] clr_addr;
    logic              accept;

    logic              s1_valid;
    logic [ADDR_W-1:0] s1_addr;
    logic [CNT_W-1:0]  s1_incr;
    logic [CNT_W-1:0]  ram_rdata;

    logic              hold_valid;
    logic [ADDR_W-1:0] hold_addr;
    logic [CNT_W-1:0]  hold_data;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr;
    logic [CNT_W-1:0]  ram_wdata;

    cnt_clear_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_clear (
        .clk     (clk),
        .rst     (rst),
        .busy    (clr_busy),
        .wr_addr (clr_addr)
    );

    assign req_ready = !rst && !clr_busy;
    assign accept    = req_valid && req_ready;

    // Stage 1: request whose RAM read is in flight.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_addr  <= '0;
            s1_incr  <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_addr <= req_addr;
                s1_incr <= req_incr;
            end
        end
    end

    // The sweep owns the write port; afterwards the parked entry does.
    always_comb begin
        if (clr_busy) begin
            ram_we    = 1'b1;
            ram_waddr = clr_addr;
            ram_wdata = '0;
        end else begin
            ram_we    = hold_valid;
            ram_waddr = hold_addr;
            ram_wdata = hold_data;
        end
    end

    cnt_ram #(.DEPTH(DEPTH), .WIDTH(CNT_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .rd_en   (accept),
        .rd_addr (req_addr),
        .rd_data (ram_rdata),
        .wr_en   (ram_we),
        .wr_addr (ram_waddr),
        .wr_data (ram_wdata)
    );

    cnt_fwd_stage #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fwd (
        .clk        (clk),
        .rst        (rst),
        .s1_valid   (s1_valid),
        .s1_addr    (s1_addr),
        .s1_incr    (s1_incr),
        .ram_rdata  (ram_rdata),
        .hold_valid (hold_valid),
        .hold_addr  (hold_addr),
        .hold_data  (hold_data)
    );

    assign rsp_valid = hold_valid;
    assign rsp_addr  = hold_addr;
    assign rsp_value = hold_data;

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid == $past(req_valid && req_ready, 2));

    // R8
    no_rsp_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(rst)) |=> ##1 !rsp_valid);

    // R3
    rsp_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(rst, 2)) |-> rsp_addr == $past(req_addr, 2));

endmodule

// File: tb/rmw_count_table_bench.sv
module rmw_count_table_bench;

    localparam int DEPTH  = 16;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [CNT_W-1:0]  req_incr = '0;
    logic              rsp_valid;
    logic [ADDR_W-1:0] rsp_addr;
    logic [CNT_W-1:0]  rsp_value;

    always #10 clk = ~clk;   // 50 MHz

    rmw_count_table #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rmw_count_table (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_incr  (req_incr),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_value (rsp_value)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    logic [CNT_W-1:0]  model [DEPTH];
    logic [CNT_W-1:0]  q_val  [$];
    logic [ADDR_W-1:0] q_addr [$];
    int                q_due  [$];
    string             q_tag  [$];

    function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                     input logic [CNT_W-1:0] inc);
        logic [CNT_W:0] wide;
        wide = {1'b0, cur} + {1'b0, inc};
        return wide[CNT_W-1:0];   // wrap modulo 2^CNT_W
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs();
        if (rsp_valid) begin
            if (q_val.size() == 0) begin
                chk(1'b0, "R8", "response with nothing accepted", 1, 0);
            end else begin
                chk(q_due[0] == cyc, "R2", "response cycle", cyc, q_due[0]);
                chk(rsp_addr == q_addr[0], "R9", "response address order", rsp_addr, q_addr[0]);
                chk(rsp_value == q_val[0], q_tag[0], "response value", rsp_value, q_val[0]);
                void'(q_val.pop_front()); void'(q_addr.pop_front());
                void'(q_due.pop_front()); void'(q_tag.pop_front());
            end
        end else if (q_val.size() != 0 && q_due[0] <= cyc) begin
            chk(1'b0, "R2", "missing response", 0, 1);
            void'(q_val.pop_front()); void'(q_addr.pop_front());
            void'(q_due.pop_front()); void'(q_tag.pop_front());
        end
    endtask

    task automatic step(input bit v, input logic [ADDR_W-1:0] a,
                        input logic [CNT_W-1:0] inc, input string tag);
        @(negedge clk);
        cyc++;
        check_outputs();
        req_valid = v;
        req_addr  = a;
        req_incr  = inc;
        if (v && req_ready) begin
            model[a] = next_count(model[a], inc);
            q_val.push_back(model[a]);
            q_addr.push_back(a);
            q_due.push_back(cyc + 2);
            q_tag.push_back(tag);
        end
    endtask

    task automatic do_reset();
        int lowcnt;
        @(negedge clk);
        cyc++;
        rst = 1'b1;
        req_valid = 1'b0;
        q_val.delete(); q_addr.delete(); q_due.delete(); q_tag.delete();
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        @(negedge clk);
        cyc++;
        chk(req_ready == 1'b0, "R1", "ready during reset", req_ready, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid during reset", rsp_valid, 0);
        @(negedge clk);
        cyc++;
        rst = 1'b0;
        lowcnt = 0;
        while (!req_ready) begin
            lowcnt++;
            // R8: offered during the sweep, must be ignored
            req_valid = 1'b1;
            req_addr  = 3;
            req_incr  = 7;
            @(negedge clk);
            cyc++;
            if (rsp_valid) chk(1'b0, "R8", "response during sweep", 1, 0);
            if (lowcnt > DEPTH + 4) break;
        end
        req_valid = 1'b0;
        chk(lowcnt == DEPTH, "R1", "ready-low cycles after reset", lowcnt, DEPTH);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) step(1'b0, '0, '0, "R2");
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        do_reset();

        // R1 / R8: cleared table, sweep-time request left no trace at entry 3
        step(1'b1, 4'd3, 8'd5, "R1");
        step(1'b1, 4'd0, 8'd1, "R1");
        step(1'b1, 4'd15, 8'd9, "R1");
        drain();

        // R4: three hits in a row
        step(1'b1, 4'd2, 8'd1, "R4");
        step(1'b1, 4'd2, 8'd1, "R4");
        step(1'b1, 4'd2, 8'd1, "R4");
        drain();

        // R5: A B A
        step(1'b1, 4'd9, 8'd4, "R5");
        step(1'b1, 4'd10, 8'd2, "R5");
        step(1'b1, 4'd9, 8'd4, "R5");
        drain();

        // R6: update, idle, update
        step(1'b1, 4'd7, 8'd1, "R6");
        step(1'b0, 4'd7, 8'd0, "R6");
        step(1'b0, 4'd7, 8'd0, "R6");
        step(1'b1, 4'd7, 8'd1, "R6");
        step(1'b0, 4'd7, 8'd0, "R6");
        step(1'b1, 4'd7, 8'd3, "R6");
        drain();

        // R7: wrap-around, back to back and after a gap
        step(1'b1, 4'd5, 8'hFE, "R7");
        step(1'b1, 4'd5, 8'd5, "R7");
        step(1'b0, 4'd5, 8'd0, "R7");
        step(1'b1, 4'd5, 8'hFF, "R7");
        drain();

        // R3: random traffic biased toward three hot entries
        for (int n = 0; n < 4000; n++) begin
            bit v;
            logic [ADDR_W-1:0] a;
            v = ($urandom % 4) != 0;
            a = ($urandom % 2 == 0) ? ADDR_W'($urandom % 3) : ADDR_W'($urandom % DEPTH);
            step(v, a, CNT_W'($urandom), "R3");
        end

        // R1: reset in the middle of traffic clears everything
        step(1'b1, 4'd1, 8'd3, "R3");
        do_reset();
        step(1'b1, 4'd1, 8'd6, "R1");
        step(1'b1, 4'd2, 8'd2, "R1");
        step(1'b1, 4'd1, 8'd6, "R4");
        drain();

        for (int n = 0; n < 2000; n++) begin
            step(($urandom % 3) != 0, ADDR_W'($urandom % 4), CNT_W'($urandom), "R3");
        end
        drain();

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule